// File: doc/BRIEF.md
# Multilevel Prioritized Interrupt Controller

This block sits between a set of interrupt request lines and a small processor core. It decides which pending request the core should take next. Each source line has its own enable and a two-bit priority setting. Three per-level enables and one global enable gate all maskable requests. A separate non-maskable request bypasses every enable.

The controller records which priority levels have handlers in progress, so a request is offered only when it can preempt the work that is already running. The highest open level wins. Inside a level the lowest source index wins. For the low level only, a rotating start point can be selected instead, so that every low-level source gets its turn. The core takes the offer with an `ack` pulse. The controller then marks the level as busy, and the matching `reti` pulse releases it later. The delivered vector is a selectable base (application or boot region) plus an offset that grows with the source index.

Top module: `irqc_top`

## Requirements
- R1: While `rst` is high and on the first cycle after it, `core_req` is 0, `lvl_active` is 3'b000 and `nmi_active` is 0.
- R2: A source takes part in arbitration only if its request bit, its enable bit and `glob_en` are 1, its level code is not 2'b00 (2'b01 low, 2'b10 medium, 2'b11 high) and the `lvl_en` bit for that level is 1 (bit 0 low, bit 1 medium, bit 2 high); otherwise it never raises `core_req`.
- R3: Among open candidates, a higher level always wins over a lower one, whatever their indices.
- R4: With rotation off, the lowest source index wins among candidates of the same level.
- R5: A low request is offered only while no level is active. A medium request is offered only while the medium and high levels are idle. A high request is offered only while the high level is idle. No maskable request is offered while `nmi_active` is 1.
- R6: `nmi_req` wins over every maskable source and ignores all enables. It is offered again only after `nmi_active` has cleared.
- R7: `core_vec` is BASE + STRIDE*(index+1) for a maskable winner and BASE for the non-maskable one. BASE is APP_BASE when `boot_sel` is 0 and BOOT_BASE when it is 1.
- R8: `ack` while `core_req` is 1 sets `nmi_active` or the `lvl_active` bit of the delivered level on that edge, and `core_req` is 0 on the following cycle.
- R9: A `reti` pulse clears `nmi_active` if it is set. Otherwise it clears the highest set bit of `lvl_active`.
- R10: With `rr_en` at 1, acknowledging low source k makes the low-level search start at index k+1 and wrap, so source k becomes the last choice.
- R11: `core_req`, `core_vec`, `core_lvl` and `core_nmi` are registered. They show the winner one cycle after it appears, and they follow a change of winner one cycle later.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| src_req | input | N_SRC | Request lines, one per source |
| src_en | input | N_SRC | Per-source enable |
| src_lvl | input | 2*N_SRC | Level code of source i in bits [2i+1:2i] |
| lvl_en | input | 3 | Level enables: bit 0 low, bit 1 medium, bit 2 high |
| glob_en | input | 1 | Global enable for all maskable requests |
| rr_en | input | 1 | Selects rotating order in the low level |
| boot_sel | input | 1 | Selects the boot-region vector base |
| nmi_req | input | 1 | Non-maskable request |
| ack | input | 1 | Core takes the offered interrupt |
| reti | input | 1 | Core returns from a handler |
| core_req | output | 1 | Interrupt offered to the core |
| core_vec | output | VEC_W | Vector address of the offered interrupt |
| core_lvl | output | 2 | Level code of the offered interrupt |
| core_nmi | output | 1 | Offered interrupt is the non-maskable one |
| lvl_active | output | 3 | Levels with a handler in progress |
| nmi_active | output | 1 | Non-maskable handler in progress |

## Verification
On every cycle the assertions check three things. An offered interrupt never conflicts with the levels that are already active. An acknowledge sets the right active bit and withdraws the offer. A return pulse removes exactly one active level. Other behaviour depends on what was requested, so only the bench scenarios can show it: which source wins between levels and indices, the exact vector values for both bases, the one-cycle latency of the outputs, and the order in which rotation visits low sources.

// File: rtl/irqc_pkg.sv
package irqc_pkg;

    typedef enum logic [1:0] {
        LV_OFF  = 2'b00,
        LV_LOW  = 2'b01,
        LV_MED  = 2'b10,
        LV_HIGH = 2'b11
    } lvl_e;

    typedef struct packed {
        logic valid;
        logic nmi;
        lvl_e lvl;
    } kind_t;

    // True when a request at level l may preempt the handlers in progress.
    function automatic logic lvl_open(lvl_e l, logic [2:0] act, logic nmi_act);
        logic ok;
        case (l)
            LV_LOW:  ok = (act == 3'b000);
            LV_MED:  ok = (act[2:1] == 2'b00);
            LV_HIGH: ok = !act[2];
            default: ok = 1'b0;
        endcase
        return ok && !nmi_act;
    endfunction

    function automatic logic [2:0] lvl_bit(lvl_e l);
        case (l)
            LV_LOW:  return 3'b001;
            LV_MED:  return 3'b010;
            LV_HIGH: return 3'b100;
            default: return 3'b000;
        endcase
    endfunction

    // Release the most urgent level in progress.
    function automatic logic [2:0] drop_top(logic [2:0] act);
        if (act[2])      return {1'b0, act[1:0]};
        else if (act[1]) return {2'b00, act[0]};
        else             return 3'b000;
    endfunction

endpackage

// File: rtl/irqc_elig.sv
module irqc_elig
    import irqc_pkg::*;
#(
    parameter int N_SRC = 8
) (
    input  logic [N_SRC-1:0]   req,
    input  logic [N_SRC-1:0]   en,
    input  logic [2*N_SRC-1:0] lvl,
    input  logic [2:0]         lvl_en,
    input  logic               glob_en,
    input  logic [2:0]         act,
    input  logic               nmi_act,
    output logic [N_SRC-1:0]   cand_low,
    output logic [N_SRC-1:0]   cand_med,
    output logic [N_SRC-1:0]   cand_high
);

    logic open_low, open_med, open_high;

    assign open_low  = lvl_open(LV_LOW,  act, nmi_act) && lvl_en[0];
    assign open_med  = lvl_open(LV_MED,  act, nmi_act) && lvl_en[1];
    assign open_high = lvl_open(LV_HIGH, act, nmi_act) && lvl_en[2];

    for (genvar i = 0; i < N_SRC; i++) begin : g_src
        lvl_e l;
        logic live;
        assign l    = lvl_e'(lvl[2*i +: 2]);
        assign live = req[i] && en[i] && glob_en;
        assign cand_low[i]  = live && (l == LV_LOW)  && open_low;
        assign cand_med[i]  = live && (l == LV_MED)  && open_med;
        assign cand_high[i] = live && (l == LV_HIGH) && open_high;
    end

endmodule

// File: rtl/irqc_pick.sv
module irqc_pick #(
    parameter int N_SRC  = 8,
    parameter bit ROTATE = 1'b0,
    localparam int IDX_W = (N_SRC > 1) ? $clog2(N_SRC) : 1
) (
    input  logic [N_SRC-1:0] cand,
    input  logic             rot_on,
    input  logic [IDX_W-1:0] start,
    output logic             hit,
    output logic [IDX_W-1:0] idx
);

    logic [IDX_W-1:0] f_idx, r_idx;

    // Fixed order: lowest index wins.
    always_comb begin
        f_idx = '0;
        for (int i = N_SRC - 1; i >= 0; i--) begin
            if (cand[i]) f_idx = IDX_W'(i);
        end
    end

    // Rotating order: first candidate at or after start, wrapping.
    always_comb begin
        r_idx = '0;
        for (int j = N_SRC - 1; j >= 0; j--) begin
            int k;
            k = int'(start) + j;
            if (k >= N_SRC) k = k - N_SRC;
            if (cand[k]) r_idx = IDX_W'(k);
        end
    end

    assign hit = |cand;
    assign idx = (ROTATE && rot_on) ? r_idx : f_idx;

endmodule

// File: rtl/irqc_state.sv
module irqc_state
    import irqc_pkg::*;
(
    input  logic       clk,
    input  logic       rst,
    input  logic       take,
    input  logic       take_nmi,
    input  lvl_e       take_lvl,
    input  logic       reti,
    output logic [2:0] act,
    output logic       nmi_act
);

    logic [2:0] act_n;
    logic       nmi_n;

    always_comb begin
        act_n = act;
        nmi_n = nmi_act;
        if (reti) begin
            if (nmi_act) nmi_n = 1'b0;
            else         act_n = drop_top(act);
        end
        if (take) begin
            if (take_nmi) nmi_n = 1'b1;
            else          act_n = act_n | lvl_bit(take_lvl);
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            act     <= 3'b000;
            nmi_act <= 1'b0;
        end else begin
            act     <= act_n;
            nmi_act <= nmi_n;
        end
    end

endmodule

// File: rtl/irqc_top.sv
module irqc_top
    import irqc_pkg::*;
#(
    parameter int N_SRC  = 8,
    parameter int VEC_W  = 16,
    parameter int STRIDE = 4,
    parameter logic [VEC_W-1:0] APP_BASE  = 'h0100,
    parameter logic [VEC_W-1:0] BOOT_BASE = 'h8000,
    localparam int IDX_W = (N_SRC > 1) ? $clog2(N_SRC) : 1
) (
    input  logic               clk,
    input  logic               rst,
    input  logic [N_SRC-1:0]   src_req,
    input  logic [N_SRC-1:0]   src_en,
    input  logic [2*N_SRC-1:0] src_lvl,
    input  logic [2:0]         lvl_en,
    input  logic               glob_en,
    input  logic               rr_en,
    input  logic               boot_sel,
    input  logic               nmi_req,
    input  logic               ack,
    input  logic               reti,
    output logic               core_req,
    output logic [VEC_W-1:0]   core_vec,
    output logic [1:0]         core_lvl,
    output logic               core_nmi,
    output logic [2:0]         lvl_active,
    output logic               nmi_active
);

    logic [N_SRC-1:0] cand_low, cand_med, cand_high;
    logic             hit_low, hit_med, hit_high;
    logic [IDX_W-1:0] idx_low, idx_med, idx_high;
    logic [IDX_W-1:0] rr_ptr, core_idx, win_idx;
    kind_t            win;
    logic [VEC_W-1:0] base, win_vec;
    logic             fire;

    irqc_elig #(.N_SRC(N_SRC)) u_elig (
        .req      (src_req),
        .en       (src_en),
        .lvl      (src_lvl),
        .lvl_en   (lvl_en),
        .glob_en  (glob_en),
        .act      (lvl_active),
        .nmi_act  (nmi_active),
        .cand_low (cand_low),
        .cand_med (cand_med),
        .cand_high(cand_high)
    );

    irqc_pick #(.N_SRC(N_SRC), .ROTATE(1'b1)) u_pick_low (
        .cand(cand_low), .rot_on(rr_en), .start(rr_ptr),
        .hit(hit_low), .idx(idx_low)
    );

    irqc_pick #(.N_SRC(N_SRC), .ROTATE(1'b0)) u_pick_med (
        .cand(cand_med), .rot_on(1'b0), .start('0),
        .hit(hit_med), .idx(idx_med)
    );

    irqc_pick #(.N_SRC(N_SRC), .ROTATE(1'b0)) u_pick_high (
        .cand(cand_high), .rot_on(1'b0), .start('0),
        .hit(hit_high), .idx(idx_high)
    );

    always_comb begin
        win     = '{valid: 1'b0, nmi: 1'b0, lvl: LV_OFF};
        win_idx = '0;
        if (nmi_req && !nmi_active) begin
            win = '{valid: 1'b1, nmi: 1'b1, lvl: LV_OFF};
        end else if (hit_high) begin
            win     = '{valid: 1'b1, nmi: 1'b0, lvl: LV_HIGH};
            win_idx = idx_high;
        end else if (hit_med) begin
            win     = '{valid: 1'b1, nmi: 1'b0, lvl: LV_MED};
            win_idx = idx_med;
        end else if (hit_low) begin
            win     = '{valid: 1'b1, nmi: 1'b0, lvl: LV_LOW};
            win_idx = idx_low;
        end
    end

    assign base    = boot_sel ? BOOT_BASE : APP_BASE;
    assign win_vec = win.nmi ? base
                   : base + VEC_W'((int'(win_idx) + 1) * STRIDE);
    assign fire    = ack && core_req;

    irqc_state u_state (
        .clk     (clk),
        .rst     (rst),
        .take    (fire),
        .take_nmi(core_nmi),
        .take_lvl(lvl_e'(core_lvl)),
        .reti    (reti),
        .act     (lvl_active),
        .nmi_act (nmi_active)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            core_req <= 1'b0;
            core_vec <= '0;
            core_lvl <= LV_OFF;
            core_nmi <= 1'b0;
            core_idx <= '0;
            rr_ptr   <= '0;
        end else begin
            core_req <= win.valid && !fire;
            core_vec <= win_vec;
            core_lvl <= win.lvl;
            core_nmi <= win.nmi;
            core_idx <= win_idx;
            if (fire && rr_en && !core_nmi && core_lvl == LV_LOW) begin
                rr_ptr <= (int'(core_idx) == N_SRC - 1) ? '0 : core_idx + 1'b1;
            end
        end
    end

endmodule

// File: rtl/irqc_check.sv
module irqc_check (
    input logic       clk,
    input logic       rst,
    input logic       ack,
    input logic       reti,
    input logic       core_req,
    input logic       core_nmi,
    input logic [1:0] core_lvl,
    input logic [2:0] lvl_active,
    input logic       nmi_active
);

    AST_TAKE_DROPS_REQ: assert property (@(posedge clk) disable iff (rst)
        (ack && core_req) |=> !core_req); // R8

    AST_TAKE_SETS_NMI: assert property (@(posedge clk) disable iff (rst)
        (ack && core_req && core_nmi) |=> nmi_active); // R8

    AST_TAKE_SETS_HIGH: assert property (@(posedge clk) disable iff (rst)
        (ack && core_req && !core_nmi && core_lvl == 2'b11) |=> lvl_active[2]); // R8

    AST_TAKE_SETS_LOW: assert property (@(posedge clk) disable iff (rst)
        (ack && core_req && !core_nmi && core_lvl == 2'b01) |=> lvl_active[0]); // R8

    AST_NMI_NOT_NESTED: assert property (@(posedge clk) disable iff (rst)
        (core_req && core_nmi) |-> !nmi_active); // R6

    AST_LOW_NEEDS_IDLE: assert property (@(posedge clk) disable iff (rst)
        (core_req && !core_nmi && core_lvl == 2'b01) |-> (lvl_active == 3'b000 && !nmi_active)); // R5

    AST_MED_NEEDS_IDLE: assert property (@(posedge clk) disable iff (rst)
        (core_req && !core_nmi && core_lvl == 2'b10) |-> (lvl_active[2:1] == 2'b00 && !nmi_active)); // R5

    AST_HIGH_NEEDS_IDLE: assert property (@(posedge clk) disable iff (rst)
        (core_req && !core_nmi && core_lvl == 2'b11) |-> (!lvl_active[2] && !nmi_active)); // R5

    AST_OFFER_HAS_LEVEL: assert property (@(posedge clk) disable iff (rst)
        (core_req && !core_nmi) |-> core_lvl != 2'b00); // R2

    AST_RETI_DROPS_ONE: assert property (@(posedge clk) disable iff (rst)
        (reti && !ack && !nmi_active && lvl_active != 3'b000)
        |=> $countones(lvl_active) == $countones($past(lvl_active)) - 1); // R9

    AST_RETI_NMI_FIRST: assert property (@(posedge clk) disable iff (rst)
        (reti && !ack && nmi_active) |=> (!nmi_active && $stable(lvl_active))); // R9

endmodule

bind irqc_top irqc_check u_irqc_check (
    .clk       (clk),
    .rst       (rst),
    .ack       (ack),
    .reti      (reti),
    .core_req  (core_req),
    .core_nmi  (core_nmi),
    .core_lvl  (core_lvl),
    .lvl_active(lvl_active),
    .nmi_active(nmi_active)
);

// File: tb/tb_irqc_top.sv
module tb_irqc_top;

    localparam int N = 8;
    localparam logic [15:0] APPB  = 16'h0100;
    localparam logic [15:0] BOOTB = 16'h8000;

    logic          clk = 1'b0;
    logic          rst = 1'b1;
    logic [N-1:0]  src_req = '0, src_en = '1;
    logic [2*N-1:0] src_lvl = '0;
    logic [2:0]    lvl_en = 3'b111;
    logic          glob_en = 1'b1, rr_en = 1'b0, boot_sel = 1'b0;
    logic          nmi_req = 1'b0, ack = 1'b0, reti = 1'b0;
    logic          core_req, core_nmi, nmi_active;
    logic [15:0]   core_vec;
    logic [1:0]    core_lvl;
    logic [2:0]    lvl_active;

    int total = 0;
    int bad   = 0;

    always #2 clk = ~clk;

    irqc_top dut (
        .clk(clk), .rst(rst), .src_req(src_req), .src_en(src_en),
        .src_lvl(src_lvl), .lvl_en(lvl_en), .glob_en(glob_en),
        .rr_en(rr_en), .boot_sel(boot_sel), .nmi_req(nmi_req),
        .ack(ack), .reti(reti), .core_req(core_req), .core_vec(core_vec),
        .core_lvl(core_lvl), .core_nmi(core_nmi),
        .lvl_active(lvl_active), .nmi_active(nmi_active)
    );

    // req, en, lvl, expected valid, expected index, expected level
    localparam int EW = 38;
    localparam logic [EW-1:0] TBL [8] = '{
        {8'h01, 8'h01, 16'h0001, 1'b1, 3'd0, 2'b01},  // R4 single low
        {8'h81, 8'hFF, 16'hC001, 1'b1, 3'd7, 2'b11},  // R3 high beats low
        {8'h24, 8'hFF, 16'h0820, 1'b1, 3'd2, 2'b10},  // R4 two medium
        {8'h10, 8'h00, 16'h0300, 1'b0, 3'd0, 2'b00},  // R2 source disabled
        {8'h08, 8'hFF, 16'h0000, 1'b0, 3'd0, 2'b00},  // R2 level code off
        {8'h42, 8'hFF, 16'h2004, 1'b1, 3'd6, 2'b10},  // R3 medium beats low
        {8'hFF, 8'hFF, 16'hFFFF, 1'b1, 3'd0, 2'b11},  // R4 all high
        {8'hC0, 8'h80, 16'hF000, 1'b1, 3'd7, 2'b11}   // R2 masked low index
    };

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic tick();
        @(posedge clk);
        @(negedge clk);
    endtask

    task automatic do_ack();
        ack = 1'b1;
        tick();
        ack = 1'b0;
    endtask

    task automatic do_reti();
        reti = 1'b1;
        tick();
        reti = 1'b0;
    endtask

    task automatic set_src(input int i, input logic [1:0] l, input logic r);
        src_lvl[2*i +: 2] = l;
        src_req[i] = r;
    endtask

    function automatic logic [15:0] vec_of(input logic [15:0] b, input int i);
        return b + 16'(4 * (i + 1));
    endfunction

    initial begin
        repeat (100000) @(posedge clk);
        total++;
        bad++;
        $display("FAIL watchdog actual=hung expected=finish");
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        @(negedge clk);
        repeat (3) tick();
        // R1 reset state
        chk("R1 req", core_req, 0);
        chk("R1 active", lvl_active, 0);
        chk("R1 nmi", nmi_active, 0);
        rst = 1'b0;
        tick();
        chk("R1 req after", core_req, 0);

        // Table walk: no handler active, rotation off
        for (int e = 0; e < 8; e++) begin
            logic [EW-1:0] v;
            v = TBL[e];
            src_req = v[37:30];
            src_en  = v[29:22];
            src_lvl = v[21:6];
            tick();
            chk("R2/R3/R4 valid", core_req, v[5]);
            if (v[5]) begin
                chk("R3/R4 level", core_lvl, v[1:0]);
                chk("R7 vector", core_vec, vec_of(APPB, int'(v[4:2])));
            end
        end
        src_req = '0; src_en = '1; src_lvl = '0;
        tick();

        // R2 level enable and global enable
        set_src(0, 2'b01, 1'b1);
        lvl_en = 3'b110;
        tick();
        chk("R2 level enable off", core_req, 0);
        lvl_en = 3'b111;
        glob_en = 1'b0;
        tick();
        chk("R2 global enable off", core_req, 0);
        glob_en = 1'b1;
        set_src(0, 2'b00, 1'b0);
        tick();

        // R11 latency and follow
        set_src(3, 2'b01, 1'b1);
        chk("R11 not yet", core_req, 0);
        tick();
        chk("R11 raised", core_req, 1);
        chk("R7 low vec", core_vec, vec_of(APPB, 3));
        set_src(4, 2'b11, 1'b1);
        chk("R11 old winner held", core_vec, vec_of(APPB, 3));
        tick();
        chk("R11 follows winner", core_lvl, 2'b11);
        chk("R11 follows vec", core_vec, vec_of(APPB, 4));

        // R8 take high, R5 blocking
        do_ack();
        chk("R8 req drops", core_req, 0);
        chk("R8 high active", lvl_active, 3'b100);
        tick();
        chk("R5 low blocked by high", core_req, 0);
        set_src(5, 2'b10, 1'b1);
        tick();
        chk("R5 medium blocked by high", core_req, 0);
        do_reti();
        chk("R9 high released", lvl_active, 3'b000);
        set_src(4, 2'b11, 1'b0);
        tick();
        chk("R3 medium offered", core_lvl, 2'b10);
        chk("R7 medium vec", core_vec, vec_of(APPB, 5));
        do_ack();
        chk("R8 medium active", lvl_active, 3'b010);
        tick();
        chk("R5 low blocked by medium", core_req, 0);
        set_src(6, 2'b11, 1'b1);
        tick();
        chk("R5 high preempts medium", core_req, 1);
        chk("R5 high level", core_lvl, 2'b11);
        boot_sel = 1'b1;
        tick();
        chk("R7 boot base vec", core_vec, vec_of(BOOTB, 6));
        do_ack();
        chk("R8 nested active", lvl_active, 3'b110);
        set_src(6, 2'b11, 1'b0);
        set_src(5, 2'b10, 1'b0);
        do_reti();
        chk("R9 highest cleared", lvl_active, 3'b010);
        do_reti();
        chk("R9 next cleared", lvl_active, 3'b000);
        tick();
        chk("R5 low offered when idle", core_req, 1);

        // R6 NMI ignores enables
        glob_en = 1'b0;
        nmi_req = 1'b1;
        tick();
        chk("R6 nmi offered", core_nmi, 1);
        chk("R6 nmi req", core_req, 1);
        chk("R7 nmi vec", core_vec, BOOTB);
        do_ack();
        chk("R8 nmi active", nmi_active, 1);
        tick();
        chk("R6 nmi not nested", core_req, 0);
        do_reti();
        chk("R9 nmi cleared", nmi_active, 0);
        nmi_req = 1'b0;
        glob_en = 1'b1;
        boot_sel = 1'b0;
        tick();

        // R9 NMI cleared before levels
        chk("R4 low back", core_vec, vec_of(APPB, 3));
        do_ack();
        chk("R8 low active", lvl_active, 3'b001);
        nmi_req = 1'b1;
        tick();
        chk("R6 nmi over low handler", core_nmi & core_req, 1);
        do_ack();
        nmi_req = 1'b0;
        do_reti();
        chk("R9 nmi first", nmi_active, 0);
        chk("R9 low kept", lvl_active, 3'b001);
        do_reti();
        chk("R9 low cleared", lvl_active, 3'b000);
        src_req = '0;
        src_lvl = '0;
        tick();

        // R10 rotation among low sources 1, 3, 6
        rr_en = 1'b1;
        set_src(1, 2'b01, 1'b1);
        set_src(3, 2'b01, 1'b1);
        set_src(6, 2'b01, 1'b1);
        begin
            int exp_seq [4] = '{1, 3, 6, 1};
            for (int r = 0; r < 4; r++) begin
                tick();
                chk("R10 rotation", core_vec, vec_of(APPB, exp_seq[r]));
                do_ack();
                do_reti();
            end
        end
        rr_en = 1'b0;
        tick();
        chk("R4 fixed after rotation off", core_vec, vec_of(APPB, 1));

        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule